// File: doc/BRIEF.md
# RISC-V Integer ALU

A purely combinational arithmetic and logic unit for a single-cycle 32-bit RISC-V integer core. It takes two operands and picks one of ten operations straight from the instruction's `funct3` field, qualified by instruction bit 30. The operations are add, subtract, three shifts, signed and unsigned set-less-than, XOR, OR and AND. It returns the result together with a flag that is high when the result is zero.

Register-register and register-immediate instructions use the same unit. The decoder passes instruction bit 30 on `alt_bit`. It raises `alt_valid` when that bit really is an opcode qualifier, which holds for register-register operations. For the immediate add, bit 30 is ordinary immediate data, so `alt_valid` is held low and the add is never turned into a subtract. Both shift-right forms always treat bit 30 as the arithmetic/logical selector, in both the register and the immediate encoding.

Top module: `int_alu`

## Requirements
- R1: With `funct3` = 000 and not (`alt_bit` = 1 and `alt_valid` = 1), `result` = `op_a` + `op_b` modulo 2^32.
- R2: With `funct3` = 000, `alt_bit` = 1 and `alt_valid` = 1, `result` = `op_a` − `op_b` modulo 2^32.
- R3: With `funct3` = 001, `result` = `op_a` shifted left by `op_b[4:0]`, with zeros filled in. `op_b[31:5]` has no effect.
- R4: With `funct3` = 101, the shift is right by `op_b[4:0]`. It fills with zeros when `alt_bit` = 0, and with copies of `op_a[31]` when `alt_bit` = 1. `alt_valid` and `op_b[31:5]` have no effect.
- R5: With `funct3` = 010, `result` = 1 when `op_a` < `op_b` as signed two's-complement values, else 0. Bits 31:1 are always 0.
- R6: With `funct3` = 011, `result` = 1 when `op_a` < `op_b` as unsigned values, else 0. Bits 31:1 are always 0.
- R7: `funct3` = 100, 110 and 111 give bitwise XOR, OR and AND of the operands.
- R8: For every `funct3` other than 000 and 101, `alt_bit` and `alt_valid` have no effect on `result`.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (rs1) |
| op_b | input | 32 | Second operand (rs2 or immediate) |
| funct3 | input | 3 | Operation select from the instruction |
| alt_bit | input | 1 | Instruction bit 30 |
| alt_valid | input | 1 | High when bit 30 qualifies the add/subtract choice |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Two pieces of behaviour always come out of the same evaluation: the operation result and the zero flag. In addition, a compare and a subtract share one adder, so the subtract path is exercised whenever a set-less-than is selected. The bench provokes the overlap in two ways. It sends equal operands through subtract and XOR, which should give a zero result with the flag raised. It sends operand pairs that cross the sign boundary through both compares, where signed and unsigned answers differ. Each result and its flag are judged together, against a reference model written from the requirements, for the same input vector.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [2:0]      funct3,
  input  logic            alt_bit,
  input  logic            alt_valid,
  output logic [XLEN-1:0] result,
  output logic            zero
);
  localparam int SHW = $clog2(XLEN);
  localparam int MSB = XLEN - 1;

  logic            is_sub;
  logic            is_cmp;
  logic            inv_b;
  logic [XLEN:0]   sum;
  logic            lt_s;
  logic            lt_u;

  assign is_sub = (funct3 == 3'b000) && alt_bit && alt_valid;
  assign is_cmp = (funct3 == 3'b010) || (funct3 == 3'b011);
  assign inv_b  = is_sub || is_cmp;
  assign sum    = {1'b0, op_a} + {1'b0, op_b ^ {XLEN{inv_b}}} + {{XLEN{1'b0}}, inv_b};
  assign lt_u   = ~sum[XLEN];
  assign lt_s   = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : sum[MSB];

  logic            shl;
  logic            fill;
  logic [XLEN-1:0] a_rev;
  logic [XLEN-1:0] stage [SHW+1];
  logic [XLEN-1:0] sh_right;
  logic [XLEN-1:0] sh_left;

  assign shl  = (funct3 == 3'b001);
  assign fill = alt_bit & op_a[MSB] & ~shl;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign a_rev[i]   = op_a[MSB-i];
    assign sh_left[i] = sh_right[MSB-i];
  end

  assign stage[0] = shl ? a_rev : op_a;
  for (genvar s = 0; s < SHW; s++) begin : g_shift
    localparam int D = 1 << s;
    assign stage[s+1] = op_b[s] ? {{D{fill}}, stage[s][MSB:D]} : stage[s];
  end
  assign sh_right = stage[SHW];

  always_comb begin
    unique case (funct3)
      3'b000:  result = sum[MSB:0];
      3'b001:  result = sh_left;
      3'b010:  result = {{(XLEN-1){1'b0}}, lt_s};
      3'b011:  result = {{(XLEN-1){1'b0}}, lt_u};
      3'b100:  result = op_a ^ op_b;
      3'b101:  result = sh_right;
      3'b110:  result = op_a | op_b;
      default: result = op_a & op_b;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [2:0]      funct3,
  input logic            alt_bit,
  input logic            alt_valid,
  input logic [XLEN-1:0] result,
  input logic            zero
);
  logic known;
  assign known = !$isunknown({op_a, op_b, funct3, alt_bit, alt_valid, result, zero});

  always_comb begin
    if (known) begin
      if (funct3 == 3'b000 && !(alt_bit && alt_valid))
        assert_add_R1: assert (result == op_a + op_b);
      if (funct3 == 3'b000 && alt_bit && alt_valid)
        assert_sub_R2: assert (result + op_b == op_a);
      if (funct3 == 3'b001 && op_b[4:0] == 5'd0)
        assert_shl_zero_R3: assert (result == op_a);
      if (funct3 == 3'b101 && alt_bit && op_a[XLEN-1])
        assert_sra_sign_R4: assert (result[XLEN-1]);
      if (funct3 == 3'b010 || funct3 == 3'b011)
        assert_slt_width_R5: assert (result[XLEN-1:1] == '0);
      if (funct3 == 3'b111)
        assert_and_subset_R7: assert ((result & ~op_a) == '0);
      if (funct3 == 3'b100 && op_a == op_b)
        assert_xor_self_zero_R9: assert (zero);
    end
  end
endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_int_alu.sv
module test_int_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic [31:0] op_a, op_b, result;
  logic [2:0]  funct3;
  logic        alt_bit, alt_valid, zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu i_int_alu (
    .op_a(op_a), .op_b(op_b), .funct3(funct3),
    .alt_bit(alt_bit), .alt_valid(alt_valid),
    .result(result), .zero(zero)
  );

  function automatic logic [31:0] ref_op(logic [31:0] a, logic [31:0] b,
                                         logic [2:0] f, logic alt, logic vld);
    case (f)
      3'b000:  return (alt && vld) ? a - b : a + b;
      3'b001:  return a << b[4:0];
      3'b010:  return {31'd0, $signed(a) < $signed(b)};
      3'b011:  return {31'd0, a < b};
      3'b100:  return a ^ b;
      3'b101:  return alt ? $unsigned($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'b110:  return a | b;
      default: return a & b;
    endcase
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] f,
                       logic alt, logic vld, string tag);
    item_t it;
    @(posedge clk);
    op_a = a; op_b = b; funct3 = f; alt_bit = alt; alt_valid = vld;
    it.exp = ref_op(a, b, f, alt, vld);
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (result !== it.exp) begin
        fails++;
        $display("FAIL %s result: actual %h expected %h", it.tag, result, it.exp);
      end
      checks++;
      if (zero !== (it.exp == 32'd0)) begin
        fails++;
        $display("FAIL R9 zero (%s): actual %b expected %b", it.tag, zero, it.exp == 32'd0);
      end
    end
  end

  initial begin
    op_a = '0; op_b = '0; funct3 = '0; alt_bit = 1'b0; alt_valid = 1'b0;
    apply(32'd0, 32'd0, 3'b000, 1'b0, 1'b0, "R1 zero inputs");
    apply(32'h7fff_ffff, 32'd1, 3'b000, 1'b0, 1'b1, "R1 overflow");
    apply(32'h0000_1234, 32'd5, 3'b000, 1'b1, 1'b0, "R1 imm bit30 ignored");
    apply(32'd5, 32'd7, 3'b000, 1'b1, 1'b1, "R2 negative diff");
    apply(32'h8000_0000, 32'd1, 3'b000, 1'b1, 1'b1, "R2 wrap");
    apply(32'hdead_beef, 32'hdead_beef, 3'b000, 1'b1, 1'b1, "R2 equal gives zero");
    apply(32'h8000_0001, 32'hffff_ffe4, 3'b001, 1'b0, 1'b1, "R3 upper b ignored");
    apply(32'h0000_0001, 32'd31, 3'b001, 1'b1, 1'b1, "R3 shift 31");
    apply(32'h8000_0000, 32'd31, 3'b101, 1'b0, 1'b1, "R4 srl 31");
    apply(32'h8000_0000, 32'd31, 3'b101, 1'b1, 1'b1, "R4 sra 31");
    apply(32'hf0f0_0000, 32'hffff_ff04, 3'b101, 1'b1, 1'b0, "R4 srai alt_valid low");
    apply(32'h7000_0000, 32'd4, 3'b101, 1'b1, 1'b1, "R4 sra positive");
    apply(32'h8000_0000, 32'd1, 3'b010, 1'b0, 1'b0, "R5 neg < pos");
    apply(32'd1, 32'h8000_0000, 32'b010, 1'b1, 1'b1, "R5 pos not < neg");
    apply(32'hffff_ffff, 32'hffff_ffff, 3'b010, 1'b0, 1'b0, "R5 equal");
    apply(32'h8000_0000, 32'd1, 3'b011, 1'b0, 1'b0, "R6 big not < 1");
    apply(32'd1, 32'h8000_0000, 3'b011, 1'b0, 1'b0, "R6 1 < big");
    apply(32'h1234_5678, 32'h1234_5678, 3'b100, 1'b0, 1'b0, "R7 xor self");
    apply(32'hf0f0_1234, 32'h0f0f_4321, 3'b110, 1'b0, 1'b0, "R7 or");
    apply(32'hf0f0_ffff, 32'h0ff0_00ff, 3'b111, 1'b0, 1'b0, "R7 and");
    apply(32'ha5a5_a5a5, 32'h0000_ffff, 3'b100, 1'b1, 1'b1, "R8 xor with alt");
    apply(32'h0000_0003, 32'd2, 3'b001, 1'b1, 1'b1, "R8 sll with alt");
    apply(32'h0000_0003, 32'd9, 3'b011, 1'b1, 1'b1, "R8 sltu with alt");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [2:0]  f;
      a = $urandom; b = $urandom; f = 3'($urandom);
      if (n % 7 == 0) b = a;
      apply(a, b, f, 1'($urandom), 1'($urandom), "R1-R9 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule